// File: doc/BRIEF.md
# Initiator Wake-Request Traffic Gate

This block sits between one bus initiator and the on-chip interconnect, in the always-on region of the chip. Each transaction carries a target index, and a status vector reports which target power islands are currently powered. When the addressed island is up, the transaction goes straight through to the interconnect in the same cycle.

When the addressed island is down, the transaction is not forwarded. The gate accepts it into a holding register and raises a wake request, naming the target, toward the central power manager. It keeps the request up until the manager grants it. The manager grants only once the island is back on. After the grant the gate presents the held transaction downstream and keeps presenting it until it is accepted. The initiator is stalled for the whole of this sequence.

A transaction whose target index is outside the configured target count is swallowed and flagged, and is never forwarded. This scheme avoids the deadlock in which traffic to a sleeping target blocks the very path that would wake it.

Top module: `wake_gate`

## Requirements
- R1: With the gate idle, a transaction whose target index is below NUM_TGT and whose `dom_on` bit is 1 appears on `out_valid`/`out_idx`/`out_data` in the same cycle. While it passes through, `in_ready` equals `out_ready`.
- R2: With the gate idle, a valid transaction to a powered-down legal target is accepted (`in_ready` = 1 that cycle) and does not appear on `out_valid`. From the next cycle until the held transaction is delivered, `in_ready` is 0 and no other input transaction is taken.
- R3: `wake_req` goes to 1 in the cycle after a transaction is held, with `wake_tgt` equal to the held index. It stays at 1, with `wake_tgt` unchanged, for every cycle in which `wake_gnt` is 0. In the cycle after `wake_gnt` is sampled at 1, it returns to 0. Each held transaction produces exactly one such request window.
- R4: In the cycle after `wake_gnt` is sampled at 1 during a request, `out_valid` is 1 and `out_idx`/`out_data` carry the held transaction. A `wake_gnt` pulse while no request is pending has no effect on any output.
- R5: While the held transaction is presented and `out_ready` is 0, `out_valid` stays 1 and `out_idx`/`out_data` stay unchanged. One cycle after it is accepted, the gate is idle again and `out_valid` is 0 unless a new pass-through transaction is present.
- R6: A valid transaction with target index at or above NUM_TGT (6 and 7 for the default 3-bit index) is accepted while idle and never appears on `out_valid`. No wake request is raised for it. `err_badidx` is 1 for exactly the following cycle.
- R7: After reset, `out_valid`, `wake_req` and `err_badidx` are 0, and the gate is idle.
- R8: While a transaction is held, changes on `dom_on` and on the input channel have no effect. The gate forwards only after the grant, and it forwards the held payload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Initiator transaction valid |
| in_ready | output | 1 | Gate accepts the initiator transaction |
| in_idx | input | IDX_W | Target index of the initiator transaction |
| in_data | input | DATA_W | Transaction payload |
| out_valid | output | 1 | Transaction valid toward the interconnect |
| out_ready | input | 1 | Interconnect accepts the transaction |
| out_idx | output | IDX_W | Target index toward the interconnect |
| out_data | output | DATA_W | Payload toward the interconnect |
| dom_on | input | NUM_TGT | Per-target island powered status, 1 = on |
| wake_req | output | 1 | Wake request to the power manager |
| wake_tgt | output | IDX_W | Target index named by the wake request |
| wake_gnt | input | 1 | Power manager answer: the target is back on |
| err_badidx | output | 1 | One-cycle flag for a dropped out-of-range transaction |

## Verification
Two events can coincide: the grant can arrive in the very first cycle the request is visible, and the initiator can keep a new transaction pending while the held one drains. The bench provokes the first by driving `wake_gnt` as soon as `wake_req` is seen. It provokes the second by keeping `in_valid` high with changing index, payload and `dom_on` throughout the hold. It then judges that the forwarded payload is the held one, that `in_ready` stays 0 until delivery, and that the request window closes exactly one cycle after the grant.

// File: rtl/wake_gate_pkg.sv
package wake_gate_pkg;

    // Controller states of the gate
    typedef enum logic [1:0] {
        GS_IDLE       = 2'd0,
        GS_HOLD_REQ   = 2'd1,
        GS_WAIT_GRANT = 2'd2,
        GS_FORWARD    = 2'd3
    } gate_state_e;

    // Classification of the incoming transaction
    typedef enum logic [1:0] {
        RT_NONE = 2'd0,
        RT_PASS = 2'd1,
        RT_PARK = 2'd2,
        RT_DROP = 2'd3
    } route_e;

    function automatic logic idx_in_range(input int unsigned idx, input int unsigned count);
        return idx < count;
    endfunction

endpackage

// File: rtl/wake_gate_route.sv
module wake_gate_route
    import wake_gate_pkg::*;
#(
    parameter int NUM_TGT = 6,
    parameter int IDX_W   = 3
) (
    input  logic               in_valid,
    input  logic [IDX_W-1:0]   in_idx,
    input  logic [NUM_TGT-1:0] dom_on,
    output route_e             route
);
    localparam int SPAN = 1 << IDX_W;

    logic [SPAN-1:0] on_pad;

    // Pad the status vector to the full index span; unused slots read as off
    for (genvar i = 0; i < SPAN; i++) begin : g_pad
        if (i < NUM_TGT) begin : g_real
            assign on_pad[i] = dom_on[i];
        end else begin : g_void
            assign on_pad[i] = 1'b0;
        end
    end

    always_comb begin
        if (!in_valid) begin
            route = RT_NONE;
        end else if (!idx_in_range(32'(in_idx), NUM_TGT)) begin
            route = RT_DROP;
        end else if (on_pad[in_idx]) begin
            route = RT_PASS;
        end else begin
            route = RT_PARK;
        end
    end

endmodule

// File: rtl/wake_gate_hold.sv
module wake_gate_hold #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [IDX_W-1:0]  in_idx,
    input  logic [DATA_W-1:0] in_data,
    output logic [IDX_W-1:0]  held_idx,
    output logic [DATA_W-1:0] held_data
);
    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } held_t;

    held_t slot;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot <= '0;
        end else if (load) begin
            slot <= '{idx: in_idx, data: in_data};
        end
    end

    assign held_idx  = slot.idx;
    assign held_data = slot.data;

endmodule

// File: rtl/wake_gate_fsm.sv
module wake_gate_fsm
    import wake_gate_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  route_e      route,
    input  logic        wake_gnt,
    input  logic        out_ready,
    output gate_state_e state,
    output logic        load,
    output logic        err_q
);
    gate_state_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            GS_IDLE:       if (route == RT_PARK) state_nx = GS_HOLD_REQ;
            GS_HOLD_REQ:   state_nx = wake_gnt ? GS_FORWARD : GS_WAIT_GRANT;
            GS_WAIT_GRANT: if (wake_gnt) state_nx = GS_FORWARD;
            GS_FORWARD:    if (out_ready) state_nx = GS_IDLE;
            default:       state_nx = GS_IDLE;
        endcase
    end

    assign load = (state == GS_IDLE) && (route == RT_PARK);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= GS_IDLE;
            err_q <= 1'b0;
        end else begin
            state <= state_nx;
            err_q <= (state == GS_IDLE) && (route == RT_DROP);
        end
    end

    AST_FWD_AFTER_GNT: assert property (@(posedge clk) disable iff (rst)
        (state == GS_FORWARD && $past(state) != GS_FORWARD) |-> $past(wake_gnt)); // R4

    AST_HOLD_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
        (state == GS_HOLD_REQ) |-> $past(state) == GS_IDLE); // R3

endmodule

// File: rtl/wake_gate.sv
module wake_gate
    import wake_gate_pkg::*;
#(
    parameter int NUM_TGT = 6,
    parameter int IDX_W   = 3,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [IDX_W-1:0]   in_idx,
    input  logic [DATA_W-1:0]  in_data,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [IDX_W-1:0]   out_idx,
    output logic [DATA_W-1:0]  out_data,
    input  logic [NUM_TGT-1:0] dom_on,
    output logic               wake_req,
    output logic [IDX_W-1:0]   wake_tgt,
    input  logic               wake_gnt,
    output logic               err_badidx
);
    localparam int SPAN = 1 << IDX_W;

    initial begin
        if (NUM_TGT < 1 || NUM_TGT > SPAN) $error("NUM_TGT does not fit IDX_W");
    end

    route_e            route;
    gate_state_e       state;
    logic              load;
    logic              err_q;
    logic [IDX_W-1:0]  held_idx;
    logic [DATA_W-1:0] held_data;
    logic              idle;
    logic              fwd;

    wake_gate_route #(.NUM_TGT(NUM_TGT), .IDX_W(IDX_W)) u_route (
        .in_valid (in_valid),
        .in_idx   (in_idx),
        .dom_on   (dom_on),
        .route    (route)
    );

    wake_gate_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .route     (route),
        .wake_gnt  (wake_gnt),
        .out_ready (out_ready),
        .state     (state),
        .load      (load),
        .err_q     (err_q)
    );

    wake_gate_hold #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .in_idx    (in_idx),
        .in_data   (in_data),
        .held_idx  (held_idx),
        .held_data (held_data)
    );

    assign idle = (state == GS_IDLE);
    assign fwd  = (state == GS_FORWARD);

    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_idx   = held_idx;
        out_data  = held_data;
        if (idle) begin
            if (route == RT_PASS) begin
                out_valid = 1'b1;
                out_idx   = in_idx;
                out_data  = in_data;
                in_ready  = out_ready;
            end else begin
                in_ready  = 1'b1;
            end
        end else if (fwd) begin
            out_valid = 1'b1;
        end
    end

    assign wake_req   = (state == GS_HOLD_REQ) || (state == GS_WAIT_GRANT);
    assign wake_tgt   = held_idx;
    assign err_badidx = err_q;

    AST_PASS_SAME_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && out_valid) |-> (out_data == in_data && out_idx == in_idx && out_ready)); // R1

    AST_NO_FWD_WHILE_REQ: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> !out_valid); // R2

    AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (wake_req || fwd) |-> !in_ready); // R2

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (wake_req && !wake_gnt) |=> (wake_req && $stable(wake_tgt))); // R3

    AST_REQ_DROPS: assert property (@(posedge clk) disable iff (rst)
        (wake_req && wake_gnt) |=> (!wake_req && out_valid && out_idx == $past(wake_tgt))); // R4

    AST_FWD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (fwd && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_idx))); // R5

    AST_IDX_LEGAL: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> idx_in_range(32'(out_idx), NUM_TGT)); // R6

    AST_ERR_NO_WAKE: assert property (@(posedge clk) disable iff (rst)
        err_badidx |-> !wake_req); // R6

endmodule

// File: tb/wake_gate_test.sv
`timescale 1ns/1ps
module wake_gate_test;
    localparam int NT = 6;
    localparam int IW = 3;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [IW-1:0] in_idx = '0;
    logic [DW-1:0] in_data = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [IW-1:0] out_idx;
    logic [DW-1:0] out_data;
    logic [NT-1:0] dom_on = '0;
    logic          wake_req;
    logic [IW-1:0] wake_tgt;
    logic          wake_gnt = 1'b0;
    logic          err_badidx;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    wake_gate #(.NUM_TGT(NT), .IDX_W(IW), .DATA_W(DW)) uut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_idx(in_idx), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_idx(out_idx), .out_data(out_data),
        .dom_on(dom_on), .wake_req(wake_req), .wake_tgt(wake_tgt), .wake_gnt(wake_gnt),
        .err_badidx(err_badidx)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit exp_legal(input logic [IW-1:0] idx);
        return int'(idx) < NT;
    endfunction

    function automatic bit exp_on(input logic [IW-1:0] idx, input logic [NT-1:0] on);
        if (!exp_legal(idx)) return 1'b0;
        return on[idx];
    endfunction

    task automatic do_txn(input logic [IW-1:0] idx, input logic [DW-1:0] data,
                          input logic [NT-1:0] on, input int gdly, input int stall);
        @(negedge clk);
        in_valid = 1'b1; in_idx = idx; in_data = data; dom_on = on;
        out_ready = (stall == 0); wake_gnt = 1'b0;
        #2;
        if (!exp_legal(idx)) begin
            chk("R6", "in_ready on bad index", in_ready, 1);
            chk("R6", "out_valid on bad index", out_valid, 0);
            @(negedge clk); in_valid = 1'b0; #2;
            chk("R6", "err_badidx pulse", err_badidx, 1);
            chk("R6", "no wake_req", wake_req, 0);
            chk("R6", "not forwarded", out_valid, 0);
            @(negedge clk); #2;
            chk("R6", "err_badidx clears", err_badidx, 0);
        end else if (exp_on(idx, on)) begin
            for (int s = 0; s < stall; s++) begin
                chk("R1", "pass out_valid under stall", out_valid, 1);
                chk("R1", "in_ready follows out_ready", in_ready, 0);
                chk("R1", "pass data under stall", out_data, data);
                @(negedge clk); out_ready = (s == stall - 1); #2;
            end
            chk("R1", "pass out_valid", out_valid, 1);
            chk("R1", "pass out_idx", out_idx, idx);
            chk("R1", "pass out_data", out_data, data);
            chk("R1", "pass in_ready", in_ready, 1);
            chk("R1", "no wake on pass", wake_req, 0);
            @(negedge clk); in_valid = 1'b0; #2;
            chk("R1", "out_valid after pass", out_valid, 0);
        end else begin
            chk("R2", "held accepted", in_ready, 1);
            chk("R2", "held not forwarded", out_valid, 0);
            @(negedge clk);
            in_valid = 1'b1; in_idx = IW'($urandom % NT); in_data = ~data; dom_on = NT'($urandom);
            #2;
            chk("R3", "wake_req raised", wake_req, 1);
            chk("R3", "wake_tgt", wake_tgt, idx);
            chk("R2", "in_ready low while held", in_ready, 0);
            chk("R8", "no forward before grant", out_valid, 0);
            for (int g = 0; g < gdly; g++) begin
                @(negedge clk);
                dom_on = NT'($urandom); in_idx = IW'($urandom % NT); in_data = $urandom;
                #2;
                chk("R3", "wake_req held", wake_req, 1);
                chk("R3", "wake_tgt stable", wake_tgt, idx);
                chk("R8", "no forward while waiting", out_valid, 0);
            end
            wake_gnt = 1'b1;
            @(negedge clk); wake_gnt = 1'b0; in_valid = 1'b0; #2;
            chk("R3", "wake_req drops after grant", wake_req, 0);
            chk("R4", "forward valid", out_valid, 1);
            chk("R4", "forward idx", out_idx, idx);
            chk("R8", "forward held payload", out_data, data);
            for (int s = 0; s < stall; s++) begin
                @(negedge clk); out_ready = (s == stall - 1); #2;
                chk("R5", "forward stays valid", out_valid, 1);
                chk("R5", "forward data stable", out_data, data);
                chk("R5", "forward idx stable", out_idx, idx);
            end
            @(negedge clk); #2;
            chk("R5", "idle after accept", out_valid, 0);
            chk("R5", "in_ready back", in_ready, 1);
            chk("R3", "single request window", wake_req, 0);
        end
        out_ready = 1'b1;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        #2;
        chk("R7", "reset out_valid", out_valid, 0);
        chk("R7", "reset wake_req", wake_req, 0);
        chk("R7", "reset err", err_badidx, 0);
        @(negedge clk); rst = 1'b0; #2;
        chk("R7", "idle in_ready", in_ready, 1);
        chk("R7", "idle out_valid", out_valid, 0);

        // stray grant while idle
        @(negedge clk); wake_gnt = 1'b1; #2;
        @(negedge clk); wake_gnt = 1'b0; #2;
        chk("R4", "stray grant no forward", out_valid, 0);
        chk("R4", "stray grant no request", wake_req, 0);

        // directed corners
        do_txn(3'd2, 32'hA5A5_0001, 6'b000100, 0, 0);
        do_txn(3'd5, 32'hA5A5_0002, 6'b100000, 0, 2);
        do_txn(3'd1, 32'hA5A5_0003, 6'b111101, 0, 0);
        do_txn(3'd0, 32'hA5A5_0004, 6'b000000, 3, 2);
        do_txn(3'd6, 32'hA5A5_0005, 6'b111111, 0, 0);
        do_txn(3'd7, 32'hA5A5_0006, 6'b111111, 0, 0);
        do_txn(3'd4, 32'hA5A5_0007, 6'b101111, 1, 1);

        // random mix
        for (int n = 0; n < 400; n++) begin
            do_txn(IW'($urandom % 8), $urandom, NT'($urandom), int'($urandom % 4), int'($urandom % 3));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule